// File: doc/BRIEF.md
# Slave-SPI FPGA Configuration Loader

This block sits on the host side of a board and writes a target FPGA's configuration memory over a slave SPI link. A single `start` pulse runs the full bring-up. The block pulls the target's active-low reset and the chip select low together, then releases the reset and confirms that the target's done line has fallen. It keeps the chip select low through the target's housekeeping interval, and then streams the configuration image. The image arrives on a byte stream with valid/ready handshake and a last-byte marker. It leaves the block as SPI mode-0 frames.

When the image is complete, the block confirms that the done line has risen. It then clocks out zero bytes that supply the activation clocks the loaded design needs to start. The result is left on sticky `ok` and `err_code` outputs until the next start. A `lock` output tells other masters on the shared SPI bus to keep off it while the reset and housekeeping phases run.

Top module: `cfg_loader`

## Requirements
- R1: While `rst_n` is low and after it is released, `creset_n` is 0, `cs_n` is 1, `sck` is 0, `busy` is 0, `ok` is 0 and `err_code` is 0 (no error).
- R2: A start in idle drives `creset_n` and `cs_n` low together for exactly RST_HOLD_CYC clock cycles.
- R3: `creset_n` rises while `cs_n` stays low, and `done_in` is sampled in that first released cycle. If it is high, the run aborts with `err_code` = 3 (reset failure), `cs_n` is released and no SPI byte is sent.
- R4: After the reset check, `cs_n` stays low for HK_WAIT_CYC further cycles. It is then high for SCK_HALF cycles before the image stream starts.
- R5: Image bytes leave MSB first in SPI mode 0: `sck` idles low, `mosi` is stable at each rising edge, `sck` pulses only while `cs_n` is low, and `cs_n` stays low across the whole image.
- R6: If `done_in` is low after the last image byte, the run ends with `err_code` = 4 (load failure), `ok` = 0 and no padding bytes.
- R7: If `done_in` is high after the image, ceil(ACT_CLOCKS/8) zero bytes (7 with the default 49 clocks) are sent in their own chip-select frame. Then `ok` rises with `cs_n` high.
- R8: A start with `partial` high ends with `err_code` = 2 (unsupported) and produces no change on `cs_n`, `creset_n` or `sck`.
- R9: With CPHA not 0, or with an SCK rate CLK_HZ/(2*SCK_HALF) outside 1 MHz to 25 MHz inclusive, every start gives `err_code` = 1 (configuration) and leaves the pins idle.
- R10: `lock` is high from the first reset-hold cycle until the housekeeping wait ends or the reset check aborts, and low at all other times.
- R11: `operating` is 1 whenever `done_in` is 1 and 0 otherwise.
- R12: `in_ready` is high only during the image stream while no byte is shifting and before the last byte is taken; it is 0 in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a load (sampled in idle) |
| partial | input | 1 | Request for partial reconfiguration (refused) |
| done_in | input | 1 | Target configuration-done line |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | Image byte valid |
| in_last | input | 1 | Marks the final image byte |
| in_ready | output | 1 | Image byte accepted this cycle when valid |
| creset_n | output | 1 | Active-low target reset |
| cs_n | output | 1 | SPI chip select, active low |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | SPI data to target |
| busy | output | 1 | Sequence in progress |
| lock | output | 1 | Shared SPI bus reserved |
| ok | output | 1 | Last load finished successfully |
| err_code | output | 3 | Last result: 0 none, 1 config, 2 unsupported, 3 reset failure, 4 load failure |
| operating | output | 1 | Target reports configured |

## Verification
Two events share a single cycle: the reset release and the first sampling of `done_in`. The bench provokes this by holding `done_in` high into a start. It then judges that the abort code appears, that `lock` covered only the hold plus that one cycle, and that the SPI monitor saw no byte. The last-byte handshake and the end of the stream can also meet, because `in_ready` must drop in the cycle the marked byte is taken. The scoreboard queue judges that case: an extra or missing byte on the pins shows up as a mismatch or as a byte left in the queue.

// File: rtl/cfgld_pkg.sv
// Shared types and result codes for the configuration loader.
package cfgld_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RHOLD,
        ST_RCHK,
        ST_HKW,
        ST_GAP,
        ST_STRM,
        ST_DCHK,
        ST_PAD,
        ST_FIN
    } cfg_st_e;

    localparam logic [2:0] ERR_NONE  = 3'd0;
    localparam logic [2:0] ERR_CFG   = 3'd1;
    localparam logic [2:0] ERR_UNSUP = 3'd2;
    localparam logic [2:0] ERR_RST   = 3'd3;
    localparam logic [2:0] ERR_LOAD  = 3'd4;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/cfgld_timer.sv
// Down-counter used for every timed phase.
// Assumes: the caller loads N-1 for an N-cycle phase; zero is high once the count reaches 0.
module cfgld_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Load the count on demand, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/cfgld_shift.sv
// Byte serializer for SPI mode 0, MSB first.
// Assumes: load is asserted only while busy is low. Each half SCK period is HALF clocks.
// The first rising edge comes HALF clocks after load; busy drops after the eighth falling edge.
module cfgld_shift #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] din,
    output logic       sck,
    output logic       mosi,
    output logic       busy
);
    localparam int HCW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [7:0]     sr;
    logic [HCW-1:0] hc;
    logic [2:0]     bc;

    // Half-period timing, clock toggling and shifting after each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr   <= '0;
            hc   <= '0;
            bc   <= '0;
            sck  <= 1'b0;
            busy <= 1'b0;
        end else if (load) begin
            sr   <= din;
            hc   <= '0;
            bc   <= '0;
            sck  <= 1'b0;
            busy <= 1'b1;
        end else if (busy) begin
            if (hc == HCW'(HALF - 1)) begin
                hc <= '0;
                if (!sck) begin
                    sck <= 1'b1;
                end else begin
                    sck <= 1'b0;
                    if (bc == 3'd7) begin
                        busy <= 1'b0;
                    end else begin
                        bc <= bc + 3'd1;
                        sr <= {sr[6:0], 1'b0};
                    end
                end
            end else begin
                hc <= hc + 1'b1;
            end
        end
    end

    assign mosi = sr[7];
endmodule

// File: rtl/cfg_loader.sv
// Host-side sequencer that loads a target FPGA over slave SPI.
// Sequence: reset hold with chip select low, then reset release and done-low check,
// then housekeeping wait, then image stream, then done-high check, then zero-byte activation frame.
// Assumes: done_in is already synchronous to clk. Timing parameters are given in clk cycles.
module cfg_loader
    import cfgld_pkg::*;
#(
    parameter int CLK_HZ       = 100_000_000,
    parameter int SCK_HALF     = 5,
    parameter int CPHA         = 0,
    parameter int RST_HOLD_CYC = 100,
    parameter int HK_WAIT_CYC  = 120_000,
    parameter int ACT_CLOCKS   = 49
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       partial,
    input  logic       done_in,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       in_ready,
    output logic       creset_n,
    output logic       cs_n,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       lock,
    output logic       ok,
    output logic [2:0] err_code,
    output logic       operating
);
    localparam int  SCK_HZ    = CLK_HZ / (2 * SCK_HALF);
    localparam bit  CFG_BAD   = (CPHA != 0) || (SCK_HZ < 1_000_000) || (SCK_HZ > 25_000_000);
    localparam int  PAD_BYTES = ceil_div(ACT_CLOCKS, 8);
    localparam int  PCW       = $clog2(PAD_BYTES + 1);
    localparam int  MAX_A     = (RST_HOLD_CYC > HK_WAIT_CYC) ? RST_HOLD_CYC : HK_WAIT_CYC;
    localparam int  MAXC      = (MAX_A > SCK_HALF) ? MAX_A : SCK_HALF;
    localparam int  TW        = $clog2(MAXC + 1);

    cfg_st_e        st, nxt;
    logic           cfg_ok;
    logic           tm_ld, tm_zero;
    logic [TW-1:0]  tm_val;
    logic           sh_ld, sh_busy;
    logic [7:0]     sh_din;
    logic           last_q, rel_q, ok_q;
    logic [2:0]     err_q;
    logic [PCW-1:0] pad_cnt;
    logic           acc;

    // Parameter legality picks a constant gate on the start path.
    generate
        if (CFG_BAD) begin : g_cfg_bad
            assign cfg_ok = 1'b0;
        end else begin : g_cfg_good
            assign cfg_ok = 1'b1;
        end
    endgenerate

    cfgld_timer #(.W(TW)) tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tm_ld),
        .val   (tm_val),
        .zero  (tm_zero)
    );

    cfgld_shift #(.HALF(SCK_HALF)) shf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_ld),
        .din   (sh_din),
        .sck   (sck),
        .mosi  (mosi),
        .busy  (sh_busy)
    );

    assign in_ready = (st == ST_STRM) && !sh_busy && !last_q;
    assign acc      = in_valid && in_ready;

    // Next-state, timer loads and shifter loads.
    always_comb begin
        nxt    = st;
        tm_ld  = 1'b0;
        tm_val = '0;
        sh_ld  = 1'b0;
        sh_din = in_data;
        case (st)
            ST_IDLE: begin
                if (start && cfg_ok && !partial) begin
                    nxt    = ST_RHOLD;
                    tm_ld  = 1'b1;
                    tm_val = TW'(RST_HOLD_CYC - 1);
                end
            end
            ST_RHOLD: if (tm_zero) nxt = ST_RCHK;
            ST_RCHK: begin
                if (done_in) begin
                    nxt = ST_IDLE;
                end else begin
                    nxt    = ST_HKW;
                    tm_ld  = 1'b1;
                    tm_val = TW'(HK_WAIT_CYC - 1);
                end
            end
            ST_HKW: begin
                if (tm_zero) begin
                    nxt    = ST_GAP;
                    tm_ld  = 1'b1;
                    tm_val = TW'(SCK_HALF - 1);
                end
            end
            ST_GAP: if (tm_zero) nxt = ST_STRM;
            ST_STRM: begin
                sh_ld = acc;
                if (last_q && !sh_busy) begin
                    nxt    = ST_DCHK;
                    tm_ld  = 1'b1;
                    tm_val = TW'(SCK_HALF - 1);
                end
            end
            ST_DCHK: if (tm_zero) nxt = done_in ? ST_PAD : ST_IDLE;
            ST_PAD: begin
                sh_din = 8'h00;
                if (!sh_busy) begin
                    if (pad_cnt == PCW'(PAD_BYTES)) nxt = ST_FIN;
                    else                            sh_ld = 1'b1;
                end
            end
            ST_FIN:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Last-byte flag for the image stream and count of activation bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q  <= 1'b0;
            pad_cnt <= '0;
        end else begin
            if (st == ST_GAP)          last_q <= 1'b0;
            else if (acc && in_last)   last_q <= 1'b1;
            if (st == ST_DCHK)         pad_cnt <= '0;
            else if (st == ST_PAD && sh_ld) pad_cnt <= pad_cnt + 1'b1;
        end
    end

    // Reset-line release memory: the reset stays asserted from power-on until the first release.
    always_ff @(posedge clk) begin
        if (!rst_n)                        rel_q <= 1'b0;
        else if (st == ST_RHOLD && tm_zero) rel_q <= 1'b1;
    end

    // Sticky result of the most recent start request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q  <= 1'b0;
            err_q <= ERR_NONE;
        end else begin
            if (st == ST_IDLE && start) begin
                ok_q  <= 1'b0;
                err_q <= !cfg_ok ? ERR_CFG : (partial ? ERR_UNSUP : ERR_NONE);
            end
            if (st == ST_RCHK && done_in)              err_q <= ERR_RST;
            if (st == ST_DCHK && tm_zero && !done_in)  err_q <= ERR_LOAD;
            if (st == ST_FIN)                          ok_q  <= 1'b1;
        end
    end

    assign creset_n  = (st == ST_RHOLD) ? 1'b0 : rel_q;
    assign cs_n      = !(st == ST_RHOLD || st == ST_RCHK || st == ST_HKW ||
                         st == ST_STRM  || st == ST_PAD);
    assign lock      = (st == ST_RHOLD) || (st == ST_RCHK) || (st == ST_HKW);
    assign busy      = (st != ST_IDLE);
    assign ok        = ok_q;
    assign err_code  = err_q;
    assign operating = done_in;
endmodule

// File: rtl/cfg_loader_chk.sv
// Port-level protocol checks for cfg_loader, attached with bind.
module cfg_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic lock,
    input logic cs_n,
    input logic creset_n,
    input logic sck,
    input logic in_ready,
    input logic ok
);
    AST_SCK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n); // R5

    AST_HOLD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (!creset_n && busy) |-> (!cs_n && lock)); // R2

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> ($stable(cs_n) && $stable(creset_n) && !sck)); // R8

    AST_READY_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (busy && !lock && !cs_n)); // R12

    AST_OK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok) |-> (cs_n && !busy)); // R7

    AST_LOCK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> busy); // R10
endmodule

bind cfg_loader cfg_loader_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .lock     (lock),
    .cs_n     (cs_n),
    .creset_n (creset_n),
    .sck      (sck),
    .in_ready (in_ready),
    .ok       (ok)
);

// File: tb/cfg_loader_tb_top.sv
// Scoreboard bench: drivers queue expected SPI bytes, a monitor on sck pops and compares.
module cfg_loader_tb_top;
    import cfgld_pkg::*;

    localparam int HALF = 2;
    localparam int RH   = 100;
    localparam int HK   = 300;
    localparam int PADN = 7;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0, start = 1'b0, partial = 1'b0, done_in = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0, in_last = 1'b0;
    logic       in_ready, creset_n, cs_n, sck, mosi, busy, lock, ok, operating;
    logic [2:0] err_code;

    cfg_loader #(.SCK_HALF(HALF), .RST_HOLD_CYC(RH), .HK_WAIT_CYC(HK)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .partial(partial), .done_in(done_in),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .creset_n(creset_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .busy(busy),
        .lock(lock), .ok(ok), .err_code(err_code), .operating(operating)
    );

    // Illegal configurations: phase 1, 50 MHz, about 0.98 MHz.
    localparam int BH [3] = '{2, 1, 51};
    localparam int BC [3] = '{1, 0, 0};
    logic       b_rdy [3], b_cre [3], b_cs [3], b_sck [3], b_mosi [3];
    logic       b_busy [3], b_lock [3], b_ok [3], b_op [3];
    logic [2:0] b_err [3];

    for (genvar g = 0; g < 3; g++) begin : g_bad
        cfg_loader #(.SCK_HALF(BH[g]), .CPHA(BC[g]), .RST_HOLD_CYC(RH), .HK_WAIT_CYC(HK)) bad_i (
            .clk(clk), .rst_n(rst_n), .start(start), .partial(partial), .done_in(done_in),
            .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(b_rdy[g]),
            .creset_n(b_cre[g]), .cs_n(b_cs[g]), .sck(b_sck[g]), .mosi(b_mosi[g]),
            .busy(b_busy[g]), .lock(b_lock[g]), .ok(b_ok[g]), .err_code(b_err[g]),
            .operating(b_op[g])
        );
    end

    int   n_chk = 0, n_err = 0;
    logic [7:0] exp_q [$];
    logic [7:0] mon_sr = 8'h00;
    int   mon_bits = 0, mon_bytes = 0;
    string cur_req = "R5";

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: sample mosi on rising sck inside a frame, compare each byte against the queue.
    always @(posedge sck) begin
        if (!cs_n) begin
            mon_sr = {mon_sr[6:0], mosi};
            mon_bits++;
            if (mon_bits == 8) begin
                mon_bits = 0;
                mon_bytes++;
                if (exp_q.size() == 0) check_eq(cur_req, "spi byte with nothing expected", int'(mon_sr), -1);
                else                   check_eq(cur_req, "spi byte", int'(mon_sr), int'(exp_q.pop_front()));
            end
        end
    end

    task automatic pulse_start(input logic part);
        @(negedge clk);
        partial = part;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        partial = 1'b0;
    endtask

    // Driver: queue expected bytes and feed them through the valid/ready handshake.
    task automatic feed(input logic [7:0] d [$], input bit raise_done);
        foreach (d[i]) begin
            in_data  = d[i];
            in_last  = (i == d.size() - 1);
            in_valid = 1'b1;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        if (raise_done) done_in = 1'b1;
    endtask

    // Phase counters over one busy sequence, sampled at falling clock edges.
    task automatic watch(output int rst_c, output int hk_c, output int lock_c,
                         output int csf, output int gap_c);
        logic prev_cs;
        prev_cs = 1'b1;
        rst_c = 0; hk_c = 0; lock_c = 0; csf = 0; gap_c = 0;
        while (busy) begin
            if (!creset_n && !cs_n)          rst_c++;
            if (creset_n && !cs_n && lock)   hk_c++;
            if (lock)                        lock_c++;
            if (prev_cs && !cs_n)            csf++;
            if (!lock && cs_n && csf == 1)   gap_c++;
            prev_cs = cs_n;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] img [$];
        int rc, hc, lc, cf, gc, mb;

        // R1: reset state during and after reset.
        repeat (3) @(negedge clk);
        check_eq("R1", "creset_n in reset", creset_n, 0);
        check_eq("R1", "cs_n in reset", cs_n, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_eq("R1", "creset_n after reset", creset_n, 0);
        check_eq("R1", "cs_n after reset", cs_n, 1);
        check_eq("R1", "sck after reset", sck, 0);
        check_eq("R1", "busy after reset", busy, 0);
        check_eq("R1", "ok after reset", ok, 0);
        check_eq("R1", "err after reset", err_code, 0);

        // R11: status follows the done line.
        done_in = 1'b1; #1;
        check_eq("R11", "operating with done high", operating, 1);
        done_in = 1'b0; #1;
        check_eq("R11", "operating with done low", operating, 0);

        // R12: no ready in idle.
        in_valid = 1'b1; #1;
        check_eq("R12", "in_ready in idle", in_ready, 0);
        in_valid = 1'b0;

        // Successful load: R2 R4 R5 R7 R10.
        img = '{8'hA5, 8'h3C, 8'h80, 8'h01, 8'hFF};
        foreach (img[i]) exp_q.push_back(img[i]);
        for (int i = 0; i < PADN; i++) exp_q.push_back(8'h00);
        cur_req = "R5";
        mb = mon_bytes;
        done_in = 1'b0;
        pulse_start(1'b0);
        fork
            watch(rc, hc, lc, cf, gc);
            feed(img, 1'b1);
        join
        @(negedge clk);
        check_eq("R2", "reset-hold cycles", rc, RH);
        check_eq("R4", "housekeeping cycles incl. check", hc, HK + 1);
        check_eq("R4", "chip-select gap before image", gc, HALF);
        check_eq("R10", "lock cycles", lc, RH + HK + 1);
        check_eq("R10", "lock after run", lock, 0);
        check_eq("R5", "chip-select frames", cf, 3);
        check_eq("R7", "bytes on wire", mon_bytes - mb, 5 + PADN);
        check_eq("R7", "bytes left expected", exp_q.size(), 0);
        check_eq("R7", "ok", ok, 1);
        check_eq("R7", "err", err_code, ERR_NONE);
        check_eq("R3", "creset_n released", creset_n, 1);

        // R9: illegal configurations reject every start and stay idle.
        for (int g = 0; g < 3; g++) begin
            check_eq("R9", "config error code", b_err[g], ERR_CFG);
            check_eq("R9", "config creset_n idle", b_cre[g], 0);
            check_eq("R9", "config cs_n idle", b_cs[g], 1);
        end

        // R6: done stays low after the image.
        img = '{8'h12, 8'h34, 8'h56};
        foreach (img[i]) exp_q.push_back(img[i]);
        cur_req = "R6";
        mb = mon_bytes;
        done_in = 1'b0;
        pulse_start(1'b0);
        fork
            watch(rc, hc, lc, cf, gc);
            feed(img, 1'b0);
        join
        @(negedge clk);
        check_eq("R6", "err load failure", err_code, ERR_LOAD);
        check_eq("R6", "ok after failure", ok, 0);
        check_eq("R6", "bytes on wire, no padding", mon_bytes - mb, 3);
        check_eq("R6", "frames", cf, 2);

        // R3: done stuck high across the reset release.
        cur_req = "R3";
        mb = mon_bytes;
        done_in = 1'b1;
        pulse_start(1'b0);
        watch(rc, hc, lc, cf, gc);
        @(negedge clk);
        check_eq("R3", "err reset failure", err_code, ERR_RST);
        check_eq("R3", "reset-hold cycles", rc, RH);
        check_eq("R10", "lock cycles on abort", lc, RH + 1);
        check_eq("R3", "no spi bytes", mon_bytes - mb, 0);
        check_eq("R3", "cs_n after abort", cs_n, 1);
        done_in = 1'b0;

        // R8: partial request has no pin effect.
        begin
            logic cs0, cr0;
            cur_req = "R8";
            mb  = mon_bytes;
            cs0 = cs_n;
            cr0 = creset_n;
            pulse_start(1'b1);
            check_eq("R8", "busy on partial", busy, 0);
            check_eq("R8", "err unsupported", err_code, ERR_UNSUP);
            repeat (5) @(negedge clk);
            check_eq("R8", "cs_n unchanged", cs_n, cs0);
            check_eq("R8", "creset_n unchanged", creset_n, cr0);
            check_eq("R8", "no spi bytes", mon_bytes - mb, 0);
        end

        finish_run();
    end
endmodule